// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A requester presents the virtual address, a translation-enable bit and the raw table base register value. The walker then fetches one or two descriptor words through a simple word-read port. When the walk finishes it raises a one-cycle completion pulse. At that point the physical address and a fault flag are valid.

A first-level descriptor can describe a fault, a 1 MB section, or a pointer to a second-level table. That table is either coarse (256 entries) or fine (1024 entries). A second-level descriptor can describe a fault, a 64 KB large page, a 4 KB small page or a 1 KB tiny page. The walker handles one walk at a time. While a walk is under way it refuses new requests.

Top module: `tt_walker`

## Requirements
- R1: When `req_mmu_en` is 0 at acceptance, the walk makes no memory read. It completes with `pa` equal to `req_va` and `fault` 0.
- R2: The first read goes to byte address `{req_ttbase[31:14], req_va[31:20], 2'b00}`. Bits 13:0 of `req_ttbase` have no effect.
- R3: A first-level descriptor with bits 1:0 = 00 completes the walk after one read, with `fault` 1 and `pa` 0.
- R4: A first-level descriptor with bits 1:0 = 10 (section) completes after one read, with `pa` = `{desc[31:20], va[19:0]}` and `fault` 0.
- R5: A first-level descriptor with bits 1:0 = 01 (coarse) causes a second read at `{desc[31:10], va[19:12], 2'b00}`.
- R6: A first-level descriptor with bits 1:0 = 11 (fine) causes a second read at `{desc[31:12], va[19:10], 2'b00}`.
- R7: A second-level descriptor with bits 1:0 = 01 (large page) gives `pa` = `{desc[31:16], va[15:0]}`.
- R8: A second-level descriptor with bits 1:0 = 10 (small page) gives `pa` = `{desc[31:12], va[11:0]}`.
- R9: A second-level descriptor with bits 1:0 = 11 (tiny page) gives `pa` = `{desc[31:10], va[9:0]}`.
- R10: A second-level descriptor with bits 1:0 = 00 completes with `fault` 1 and `pa` 0.
- R11: `req_ready` is high only between walks, and drops the cycle after a request is accepted. `done` lasts exactly one cycle. `mem_req` and `mem_addr` hold steady until `mem_rvalid` answers.
- R12: After reset, `req_ready` is 1 while `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_mmu_en | input | 1 | Translation enable |
| req_ttbase | input | 32 | Table base register value |
| mem_req | output | 1 | Word read outstanding |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data returned (one cycle) |
| mem_rdata | input | 32 | Descriptor word read |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address (0 on fault) |
| fault | output | 1 | Translation fault |

## Verification
The assertions assume two things about the memory side. First, `mem_rvalid` arrives only while `mem_req` is high. Second, it lasts a single cycle per read, so each read yields exactly one descriptor. The bench memory model keeps to this. It answers only an outstanding read, after a random delay of zero to three cycles, and always drops `mem_rvalid` in the following cycle. Requests are presented only while `req_ready` is high. Descriptor types, base low bits and addresses are drawn at random from a fixed seed. A directed sweep covers every first-level and second-level type.

// File: rtl/tt_walker.sv
module tt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_mmu_en,
  input  logic [31:0] req_ttbase,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] pa,
  output logic        fault
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_FIN} st_t;

  st_t         st;
  logic [31:0] va_q;
  logic [31:0] addr_q;

  logic        accept;
  logic [1:0]  dtype;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_req   = (st == S_L1) || (st == S_L2);
  assign mem_addr  = addr_q;
  assign done      = (st == S_FIN);
  assign dtype     = mem_rdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pa     <= '0;
      fault  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          va_q <= req_va;
          if (req_mmu_en) begin
            addr_q <= {req_ttbase[31:14], req_va[31:20], 2'b00};
            st     <= S_L1;
          end else begin
            pa    <= req_va;
            fault <= 1'b0;
            st    <= S_FIN;
          end
        end
        S_L1: if (mem_rvalid) begin
          case (dtype)
            2'b00: begin pa <= '0; fault <= 1'b1; st <= S_FIN; end
            2'b10: begin pa <= {mem_rdata[31:20], va_q[19:0]}; fault <= 1'b0; st <= S_FIN; end
            2'b01: begin addr_q <= {mem_rdata[31:10], va_q[19:12], 2'b00}; st <= S_L2; end
            default: begin addr_q <= {mem_rdata[31:12], va_q[19:10], 2'b00}; st <= S_L2; end
          endcase
        end
        S_L2: if (mem_rvalid) begin
          fault <= 1'b0;
          case (dtype)
            2'b00: begin pa <= '0; fault <= 1'b1; end
            2'b01: pa <= {mem_rdata[31:16], va_q[15:0]};
            2'b10: pa <= {mem_rdata[31:12], va_q[11:0]};
            default: pa <= {mem_rdata[31:10], va_q[9:0]};
          endcase
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  bypass_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_mmu_en) |=> (done && !mem_req && !fault && pa == $past(req_va)));

  // R11
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R3
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == 32'd0));

  // R2
  first_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mmu_en) |=> (mem_req && mem_addr == {$past(req_ttbase[31:14]), $past(req_va[31:20]), 2'b00}));
endmodule

// File: tb/test_tt_walker.sv
module test_tt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_mmu_en = 1'b0;
  logic [31:0] req_ttbase = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] pa;
  logic        fault;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [logic [31:0]];
  int          rd_n;
  logic [31:0] rd_a [0:3];
  int          wait_left = 0;
  logic        timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_walker i_tt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_mmu_en(req_mmu_en), .req_ttbase(req_ttbase),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .pa(pa), .fault(fault)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'd0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (wait_left == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(mem_addr);
          if (rd_n < 4) rd_a[rd_n] = mem_addr;
          rd_n++;
          wait_left = $urandom_range(0, 3);
        end else wait_left--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] va, input logic en, input logic [31:0] base,
                                output logic [31:0] epa, output logic ef, output int en_rd,
                                output logic [31:0] a0, output logic [31:0] a1, output string tag);
    logic [31:0] d1, d2;
    epa = 0; ef = 0; en_rd = 0; a0 = 0; a1 = 0; tag = "R1";
    if (!en) begin epa = va; return; end
    a0 = {base[31:14], va[31:20], 2'b00};
    d1 = rd(a0); en_rd = 1;
    case (d1[1:0])
      2'b00: begin ef = 1; tag = "R3"; return; end
      2'b10: begin epa = {d1[31:20], va[19:0]}; tag = "R4"; return; end
      2'b01: a1 = {d1[31:10], va[19:12], 2'b00};
      default: a1 = {d1[31:12], va[19:10], 2'b00};
    endcase
    en_rd = 2;
    d2 = rd(a1);
    case (d2[1:0])
      2'b00: begin ef = 1; tag = "R10"; end
      2'b01: begin epa = {d2[31:16], va[15:0]}; tag = "R7"; end
      2'b10: begin epa = {d2[31:12], va[11:0]}; tag = "R8"; end
      default: begin epa = {d2[31:10], va[9:0]}; tag = "R9"; end
    endcase
    if (d1[1:0] == 2'b01) tag = {tag, "/R5"}; else tag = {tag, "/R6"};
  endfunction

  task automatic walk(input logic [31:0] va, input logic en, input logic [31:0] base);
    logic [31:0] epa, a0, a1;
    logic ef;
    int enr, guard;
    string tag;
    model(va, en, base, epa, ef, enr, a0, a1, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1; req_va = va; req_mmu_en = en; req_ttbase = base;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!done && guard < 50) begin @(negedge clk); guard++; end
    if (!done) begin chk(1'b0, "R11 walk timeout", 0, 1); return; end
    chk(pa == epa, {tag, " pa"}, pa, epa);
    chk(fault == ef, {tag, " fault"}, {31'd0, fault}, {31'd0, ef});
    chk(rd_n == enr, {tag, " read count"}, rd_n, enr);
    if (enr >= 1) chk(rd_a[0] == a0, "R2 first read address", rd_a[0], a0);
    if (enr >= 2) chk(rd_a[1] == a1, {tag, " second read address"}, rd_a[1], a1);
    @(negedge clk);
    chk(!done, "R11 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic setup(input logic [31:0] va, input logic [31:0] base,
                       input logic [1:0] t1, input logic [1:0] t2);
    logic [31:0] d1, d2, a1;
    d1 = {$urandom()} & 32'hFFFF_FFFC | {30'd0, t1};
    mem[{base[31:14], va[31:20], 2'b00}] = d1;
    if (t1 == 2'b01) a1 = {d1[31:10], va[19:12], 2'b00};
    else a1 = {d1[31:12], va[19:10], 2'b00};
    d2 = {$urandom()} & 32'hFFFF_FFFC | {30'd0, t2};
    if (t1[0]) mem[a1] = d2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1'b1;
  end

  initial begin
    logic [31:0] va, base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12
    chk(req_ready == 1'b1, "R12 ready in reset", {31'd0, req_ready}, 1);
    chk(done == 1'b0, "R12 done in reset", {31'd0, done}, 0);
    chk(mem_req == 1'b0, "R12 mem_req in reset", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !mem_req && !done, "R12 after reset", {29'd0, req_ready, mem_req, done}, 32'd4);

    // R1 directed: translation off
    walk(32'hDEAD_BEEF, 1'b0, 32'h1234_5678);
    // R2 base low bits ignored, R3 empty entry
    mem.delete();
    walk(32'h0010_0000, 1'b1, 32'h0000_7FFF);
    // R2: same walk with different low bits must match
    setup(32'hFFF0_1234, 32'h0ABC_4000, 2'b10, 2'b00);
    walk(32'hFFF0_1234, 1'b1, 32'h0ABC_7FFF);
    walk(32'hFFF0_1234, 1'b1, 32'h0ABC_4001);

    // directed sweep of every type pair (R3..R10)
    for (int t1 = 0; t1 < 4; t1++)
      for (int t2 = 0; t2 < 4; t2++) begin
        va = $urandom(); base = $urandom();
        setup(va, base, t1[1:0], t2[1:0]);
        walk(va, 1'b1, base);
      end

    for (int n = 0; n < 400 && !timed_out; n++) begin
      va = $urandom(); base = $urandom();
      setup(va, base, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      walk(va, ($urandom_range(0, 7) != 0), base);
    end

    if (timed_out) chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule